// File: doc/BRIEF.md
# Dual-Tone Keypad Period Classifier

This block decides which row tone and which column tone of a dual-tone keypad signal are present. It counts reference-clock cycles between edges. Two logic-level inputs arrive from upstream zero-crossing comparators, one for the low (row) group and one for the high (column) group. Each input passes through a two-stage synchronizer and a rising-edge detector. A period meter then adds up the cycles covered by four consecutive input periods. The four-period sum is compared in parallel against four constant windows. Each window is computed at elaboration from the reference clock rate and the nominal tone frequency. The result is a row index, a column index, a valid flag for each group and a pair flag. The block that times tone duration and drives the key code uses these outputs.

Each group has a qualifier state machine with three states:
- `Q_IDLE`: nothing matched.
- `Q_ONCE`: one matching sum seen, with a candidate index stored.
- `Q_LOCK`: two consecutive sums matched the same tone.

The machine has these transitions:
- *first-hit*: `Q_IDLE`→`Q_ONCE`.
- *confirm*: `Q_ONCE`→`Q_LOCK`, when the same index is seen again.
- *hold*: `Q_LOCK`→`Q_LOCK`.
- *retarget*: `Q_ONCE` or `Q_LOCK`→`Q_ONCE`, when a sum matches a different tone. The new candidate is stored.
- *miss*: any state→`Q_IDLE`, when a sum matches no window.
- *drop*: any state→`Q_IDLE`, on period timeout or power-down.

A group is valid in `Q_LOCK`. All outputs pass through one register stage.

An inhibit input masks the fourth column tone, so the keys in the fourth column cannot be reported. A power-down input holds every counter, synchronizer and state machine cleared.

Top module: `dtmf_period_classifier`

## Requirements
- R1: A row tone is reported with `row_idx` = 0, 1, 2, 3 for 697, 770, 852 and 941 Hz respectively.
- R2: A column tone is reported with `col_idx` = 0, 1, 2, 3 for 1209, 1336, 1477 and 1633 Hz respectively.
- R3: A tone whose measured frequency lies within ±1.5 % of a nominal tone of its group is accepted as that tone. The measurement is the sum of four consecutive periods, in cycles of the reference clock `CLK_HZ`.
- R4: A tone whose frequency deviates by more than 1.5 % from every nominal tone of its group is rejected. This includes deviations beyond 3.5 % and deviations between 1.5 % and 3.5 %. The group's valid flag stays low.
- R5: A group becomes valid only after two consecutive four-period sums fall in the same tone's window. A burst that yields only one sum never raises the valid flag.
- R6: `pair_valid` is high only while `row_valid` and `col_valid` are both high.
- R7: While `inhibit` is high, the 1633 Hz column tone is never reported. From the cycle after `inhibit` rises, `col_valid` is low whenever `col_idx` would be 3. Column tones 0 to 2 and the row group are unaffected.
- R8: While `pwr_down` is high, all outputs read as not valid from the next cycle on, and all counters are held cleared. After release, the tones must qualify again from scratch.
- R9: If no rising edge arrives within 1.25 times the longest accepted period of the group's lowest tone, that group's valid flag clears.
- R10: During and directly after reset, all valid flags and indices are 0.
- R11: While a group stays valid, its index does not change. A change to another tone drops the flag, and the flag rises again with the new index after requalification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, rate `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Holds the classifier cleared while high |
| inhibit | input | 1 | Masks the fourth column tone while high |
| low_tone | input | 1 | Squared row-group tone from the comparator |
| high_tone | input | 1 | Squared column-group tone from the comparator |
| row_idx | output | 2 | Row tone index |
| row_valid | output | 1 | Row tone qualified |
| col_idx | output | 2 | Column tone index |
| col_valid | output | 1 | Column tone qualified |
| pair_valid | output | 1 | Row and column both qualified |

## Verification
Two functions can act on the column group in the same cycle: the inhibit mask and the lock on the fourth column tone.

The bench provokes this in two ways. It raises `inhibit` while 697 + 1633 Hz is already locked, and it runs a key from the fourth column with `inhibit` already high. In both cases the column flag must fall, or never rise, while the row keeps its lock.

The bench also raises power-down in the middle of a qualified tone. A sticky monitor must see no valid flag for as long as it is held, even though measurement edges keep arriving.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    localparam int NUM_TONES = 4;
    localparam int IDX_W     = 2;

    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_ONCE = 2'd1,
        Q_LOCK = 2'd2
    } qual_state_t;

    // nominal frequency of tone idx in the row (high_grp=0) or column group
    function automatic longint tone_hz(input bit high_grp, input int idx);
        if (!high_grp) begin
            case (idx)
                0:       return 697;
                1:       return 770;
                2:       return 852;
                default: return 941;
            endcase
        end else begin
            case (idx)
                0:       return 1209;
                1:       return 1336;
                2:       return 1477;
                default: return 1633;
            endcase
        end
    endfunction

    // smallest multi-period count still within +1.5 % frequency
    function automatic longint win_min(input longint clk_hz, input int periods,
                                       input longint f_hz);
        longint num;
        longint den;
        num = longint'(periods) * clk_hz * 1000;
        den = f_hz * 1015;
        return (num + den - 1) / den;
    endfunction

    // largest multi-period count still within -1.5 % frequency
    function automatic longint win_max(input longint clk_hz, input int periods,
                                       input longint f_hz);
        longint num;
        longint den;
        num = longint'(periods) * clk_hz * 1000;
        den = f_hz * 985;
        return num / den;
    endfunction

    // single-period limit: 1.25 x longest accepted period of the tone
    function automatic longint timeout_lim(input longint clk_hz, input longint f_hz);
        return (clk_hz * 1250) / (f_hz * 985);
    endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic din,
    output logic rise
);

    logic [2:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (clear) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[1:0], din};
        end
    end

    assign rise = shreg[1] & ~shreg[2];

endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
    parameter int     CNT_W   = 16,
    parameter int     PERIODS = 4,
    parameter longint TO_LIM  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rise,
    output logic             meas_stb,
    output logic [CNT_W-1:0] meas_sum,
    output logic             timeout
);

    localparam int NP_W = (PERIODS > 2) ? $clog2(PERIODS) : 1;
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(TO_LIM);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [NP_W-1:0]  LAST = NP_W'(PERIODS - 1);
    localparam logic [NP_W-1:0]  NP1  = NP_W'(1);

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] acc;
    logic [NP_W-1:0]  nper;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            cnt      <= '0;
            acc      <= '0;
            nper     <= '0;
            meas_stb <= 1'b0;
            meas_sum <= '0;
            timeout  <= 1'b0;
        end else begin
            meas_stb <= 1'b0;
            timeout  <= 1'b0;
            if (clear) begin
                armed <= 1'b0;
                cnt   <= '0;
                acc   <= '0;
                nper  <= '0;
            end else if (rise) begin
                cnt   <= '0;
                armed <= 1'b1;
                if (armed) begin
                    if (nper == LAST) begin
                        meas_stb <= 1'b1;
                        meas_sum <= acc + cnt + ONE;
                        acc      <= '0;
                        nper     <= '0;
                    end else begin
                        acc  <= acc + cnt + ONE;
                        nper <= nper + NP1;
                    end
                end else begin
                    acc  <= '0;
                    nper <= '0;
                end
            end else if (armed) begin
                if (cnt >= LIM) begin
                    timeout <= 1'b1;
                    armed   <= 1'b0;
                    cnt     <= '0;
                    acc     <= '0;
                    nper    <= '0;
                end else begin
                    cnt <= cnt + ONE;
                end
            end
        end
    end

endmodule

// File: rtl/dtmf_tone_match.sv
module dtmf_tone_match
    import dtmf_cls_pkg::*;
#(
    parameter int     CNT_W    = 16,
    parameter longint CLK_HZ   = 3579545,
    parameter int     PERIODS  = 4,
    parameter bit     HIGH_GRP = 1'b0
) (
    input  logic [CNT_W-1:0] sum,
    input  logic             mask_top,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [NUM_TONES-1:0] in_win;
    logic [NUM_TONES-1:0] allowed;

    for (genvar t = 0; t < NUM_TONES; t++) begin : g_win
        localparam longint F = tone_hz(HIGH_GRP, t);
        localparam logic [CNT_W-1:0] LO = CNT_W'(win_min(CLK_HZ, PERIODS, F));
        localparam logic [CNT_W-1:0] HI = CNT_W'(win_max(CLK_HZ, PERIODS, F));
        assign in_win[t] = (sum >= LO) && (sum <= HI);
    end

    assign allowed = {in_win[NUM_TONES-1] & ~mask_top, in_win[NUM_TONES-2:0]};

    always_comb begin
        hit = |allowed;
        idx = '0;
        for (int t = 0; t < NUM_TONES; t++) begin
            if (allowed[t]) idx = IDX_W'(t);
        end
    end

endmodule

// File: rtl/dtmf_group_qual.sv
module dtmf_group_qual
    import dtmf_cls_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             meas_stb,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             timeout,
    input  logic             mask_top,
    output logic             grp_valid,
    output logic [IDX_W-1:0] grp_idx
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_TONES - 1);

    qual_state_t      state, state_nx;
    logic [IDX_W-1:0] cand, cand_nx;

    always_comb begin
        state_nx = state;
        cand_nx  = cand;
        if (clear || timeout) begin
            state_nx = Q_IDLE;                       // drop
        end else if (meas_stb) begin
            if (!hit) begin
                state_nx = Q_IDLE;                   // miss
            end else begin
                unique case (state)
                    Q_IDLE: begin                    // first-hit
                        state_nx = Q_ONCE;
                        cand_nx  = hit_idx;
                    end
                    Q_ONCE, Q_LOCK: begin
                        if (hit_idx == cand) begin
                            state_nx = Q_LOCK;       // confirm / hold
                        end else begin
                            state_nx = Q_ONCE;       // retarget
                            cand_nx  = hit_idx;
                        end
                    end
                    default: state_nx = Q_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_IDLE;
            cand  <= '0;
        end else begin
            state <= state_nx;
            cand  <= cand_nx;
        end
    end

    always_comb begin
        grp_valid = (state == Q_LOCK) && !(mask_top && (cand == TOP_IDX));
        grp_idx   = cand;
    end

endmodule

// File: rtl/dtmf_period_classifier.sv
module dtmf_period_classifier
    import dtmf_cls_pkg::*;
#(
    parameter longint CLK_HZ  = 3579545,
    parameter int     PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       inhibit,
    input  logic       low_tone,
    input  logic       high_tone,
    output logic [1:0] row_idx,
    output logic       row_valid,
    output logic [1:0] col_idx,
    output logic       col_valid,
    output logic       pair_valid
);

    localparam longint TO_LO = timeout_lim(CLK_HZ, tone_hz(1'b0, 0));
    localparam int     CNT_W = $clog2(longint'(PERIODS) * (TO_LO + 2));

    logic [1:0] tone_in;
    assign tone_in = {high_tone, low_tone};

    for (genvar g = 0; g < 2; g++) begin : g_grp
        localparam bit     HG = (g == 1);
        localparam longint TO = timeout_lim(CLK_HZ, tone_hz(HG, 0));

        logic             rise;
        logic             stb;
        logic             tmo;
        logic [CNT_W-1:0] sum;
        logic             hit;
        logic [IDX_W-1:0] hidx;
        logic             mask_top;
        logic             vld;
        logic [IDX_W-1:0] gidx;

        assign mask_top = HG & inhibit;

        dtmf_edge_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (pwr_down),
            .din   (tone_in[g]),
            .rise  (rise)
        );

        dtmf_period_meter #(
            .CNT_W   (CNT_W),
            .PERIODS (PERIODS),
            .TO_LIM  (TO)
        ) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (pwr_down),
            .rise     (rise),
            .meas_stb (stb),
            .meas_sum (sum),
            .timeout  (tmo)
        );

        dtmf_tone_match #(
            .CNT_W    (CNT_W),
            .CLK_HZ   (CLK_HZ),
            .PERIODS  (PERIODS),
            .HIGH_GRP (HG)
        ) u_match (
            .sum      (sum),
            .mask_top (mask_top),
            .hit      (hit),
            .idx      (hidx)
        );

        dtmf_group_qual u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (pwr_down),
            .meas_stb  (stb),
            .hit       (hit),
            .hit_idx   (hidx),
            .timeout   (tmo),
            .mask_top  (mask_top),
            .grp_valid (vld),
            .grp_idx   (gidx)
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx    <= '0;
            row_valid  <= 1'b0;
            col_idx    <= '0;
            col_valid  <= 1'b0;
            pair_valid <= 1'b0;
        end else if (pwr_down) begin
            row_idx    <= '0;
            row_valid  <= 1'b0;
            col_idx    <= '0;
            col_valid  <= 1'b0;
            pair_valid <= 1'b0;
        end else begin
            row_idx    <= g_grp[0].gidx;
            row_valid  <= g_grp[0].vld;
            col_idx    <= g_grp[1].gidx;
            col_valid  <= g_grp[1].vld;
            pair_valid <= g_grp[0].vld & g_grp[1].vld;
        end
    end

endmodule

// File: rtl/dtmf_classifier_checks.sv
module dtmf_classifier_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down,
    input logic       inhibit,
    input logic [1:0] row_idx,
    input logic       row_valid,
    input logic [1:0] col_idx,
    input logic       col_valid,
    input logic       pair_valid
);

    p_pair_needs_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (row_valid && col_valid));

    p_inhibit_masks_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit) |-> !(col_valid && (col_idx == 2'd3)));

    p_powerdown_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> (!row_valid && !col_valid && !pair_valid));

    p_row_idx_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && $past(row_valid)) |-> (row_idx == $past(row_idx)));

    p_col_idx_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && $past(col_valid)) |-> (col_idx == $past(col_idx)));

endmodule

bind dtmf_period_classifier dtmf_classifier_checks u_checks (.*);

// File: tb/test_dtmf_period_classifier.sv
module test_dtmf_period_classifier;

    localparam longint CLK_HZ = 200000;
    localparam int     NV     = 14;

    // row tone index, row deviation (per mille), column tone index,
    // column deviation, inhibit; index -1 = silent
    localparam int VEC_LO     [NV] = '{0, 1, 2, 3, 0, 3, 1,  0,   2,  0, 1,  3, -1, 2};
    localparam int VEC_LO_DEV [NV] = '{0, 0, 0, 0, 0, 0, 0, 10, -10, 50, 0, 25,  0, 0};
    localparam int VEC_HI     [NV] = '{0, 1, 2, 3, 3, 3, 2,  1,   3,  0, 2,  1,  2, 0};
    localparam int VEC_HI_DEV [NV] = '{0, 0, 0, 0, 0, 0, 0, -10, 10,  0, -50, 0,  0, 25};
    localparam bit VEC_INH    [NV] = '{0, 0, 0, 0, 0, 1, 1,  0,   0,  0, 0,  0,  0, 0};
    localparam string VTAG    [NV] = '{
        "R1 R2 key 697/1209", "R1 R2 key 770/1336", "R1 R2 key 852/1477",
        "R1 R2 key 941/1633", "R2 R7 fourth column, inhibit low",
        "R7 fourth column, inhibit high", "R7 inhibit leaves column 2",
        "R3 plus and minus 1 percent", "R3 minus and plus 1 percent",
        "R4 row 5 percent high", "R4 column 5 percent low",
        "R4 row 2.5 percent high", "R6 row silent", "R4 column 2.5 percent high"};

    logic       clk;
    logic       rst_n;
    logic       pwr_down;
    logic       inhibit;
    logic       low_tone;
    logic       high_tone;
    logic [1:0] row_idx;
    logic       row_valid;
    logic [1:0] col_idx;
    logic       col_valid;
    logic       pair_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int p_lo = 0, p_hi = 0, ph_lo = 0, ph_hi = 0;
    bit seen_row = 0, seen_col = 0, seen_any = 0;

    dtmf_period_classifier #(.CLK_HZ(CLK_HZ), .PERIODS(4)) i_dtmf_period_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down   (pwr_down),
        .inhibit    (inhibit),
        .low_tone   (low_tone),
        .high_tone  (high_tone),
        .row_idx    (row_idx),
        .row_valid  (row_valid),
        .col_idx    (col_idx),
        .col_valid  (col_valid),
        .pair_valid (pair_valid)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (row_valid) seen_row = 1;
        if (col_valid) seen_col = 1;
        if (row_valid || col_valid || pair_valid) seen_any = 1;
    end

    function automatic longint bench_hz(int grp, int t);
        longint lo [4] = '{697, 770, 852, 941};
        longint hi [4] = '{1209, 1336, 1477, 1633};
        return (grp == 0) ? lo[t] : hi[t];
    endfunction

    function automatic int period_of(int grp, int t, int dev_pm);
        longint den;
        if (t < 0) return 0;
        den = bench_hz(grp, t) * (1000 + dev_pm);
        return int'((CLK_HZ * 1000 + den / 2) / den);
    endfunction

    function automatic int exp_idx(int grp, int p);
        real fa, f, d;
        if (p == 0) return -1;
        fa = real'(CLK_HZ) / real'(p);
        for (int t = 0; t < 4; t++) begin
            f = real'(bench_hz(grp, t));
            d = (fa > f) ? (fa - f) / f : (f - fa) / f;
            if (d <= 0.015) return t;
        end
        return -1;
    endfunction

    task automatic play(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (p_lo == 0) begin low_tone = 0; ph_lo = 0; end
            else begin low_tone = (ph_lo < p_lo / 2); ph_lo = (ph_lo >= p_lo - 1) ? 0 : ph_lo + 1; end
            if (p_hi == 0) begin high_tone = 0; ph_hi = 0; end
            else begin high_tone = (ph_hi < p_hi / 2); ph_hi = (ph_hi >= p_hi - 1) ? 0 : ph_hi + 1; end
        end
    endtask

    task automatic check_out(string tag, int er, int ec);
        bit erv, ecv, epv, ok;
        erv = (er >= 0);
        ecv = (ec >= 0);
        epv = erv && ecv;
        ok  = (row_valid == erv) && (col_valid == ecv) && (pair_valid == epv) &&
              (!erv || row_idx == 2'(er)) && (!ecv || col_idx == 2'(ec));
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual rv=%0d ri=%0d cv=%0d ci=%0d pv=%0d expected rv=%0d ri=%0d cv=%0d ci=%0d pv=%0d",
                     tag, row_valid, row_idx, col_valid, col_idx, pair_valid,
                     erv, er, ecv, ec, epv);
        end
    endtask

    task automatic check_bit(string tag, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic silence(int n);
        p_lo = 0;
        p_hi = 0;
        play(n);
    endtask

    initial begin
        int er, ec;
        rst_n = 0; pwr_down = 0; inhibit = 0; low_tone = 0; high_tone = 0;
        repeat (5) @(negedge clk);
        check_out("R10 during reset", -1, -1);
        n_chk++;
        if (row_idx != 0 || col_idx != 0) begin
            n_fail++;
            $display("FAIL R10 indices in reset: actual %0d/%0d expected 0/0", row_idx, col_idx);
        end
        rst_n = 1;
        repeat (3) @(negedge clk);
        check_out("R10 after reset", -1, -1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            inhibit = VEC_INH[v];
            p_lo = period_of(0, VEC_LO[v], VEC_LO_DEV[v]);
            p_hi = period_of(1, VEC_HI[v], VEC_HI_DEV[v]);
            play(4000);
            er = exp_idx(0, p_lo);
            ec = exp_idx(1, p_hi);
            if (inhibit && ec == 3) ec = -1;
            check_out(VTAG[v], er, ec);
            silence(1200);
        end
        inhibit = 0;

        // R5: a burst giving a single four-period sum never qualifies
        seen_col = 0;
        p_hi = period_of(1, 0, 0);
        play(6 * p_hi + 20);
        silence(600);
        check_bit("R5 single measurement gives no column valid", seen_col, 1'b0);

        // R7: inhibit raised while the fourth column is locked
        p_lo = period_of(0, 0, 0);
        p_hi = period_of(1, 3, 0);
        play(4000);
        check_out("R7 baseline fourth column", 0, 3);
        inhibit = 1;
        play(3);
        check_out("R7 inhibit raised mid-tone", 0, -1);
        play(3000);
        check_out("R7 inhibit held, row kept", 0, -1);
        inhibit = 0;
        silence(1200);

        // R11: direct switch between keys
        p_lo = period_of(0, 0, 0);
        p_hi = period_of(1, 0, 0);
        play(4000);
        check_out("R11 first key", 0, 0);
        p_lo = period_of(0, 2, 0);
        p_hi = period_of(1, 2, 0);
        play(4000);
        check_out("R11 switched key", 2, 2);
        silence(1200);

        // R9: timeout after tone stops
        p_lo = period_of(0, 1, 0);
        p_hi = period_of(1, 1, 0);
        play(4000);
        check_out("R9 tone locked", 1, 1);
        silence(800);
        check_out("R9 timeout clears both groups", -1, -1);

        // R8: power-down mid-tone
        p_lo = period_of(0, 3, 0);
        p_hi = period_of(1, 2, 0);
        play(4000);
        check_out("R8 tone locked", 3, 2);
        pwr_down = 1;
        play(3);
        check_out("R8 outputs cleared on power-down", -1, -1);
        seen_any = 0;
        play(2000);
        check_bit("R8 nothing valid while powered down", seen_any, 1'b0);
        pwr_down = 0;
        seen_row = 0;
        play(20);
        check_bit("R8 requalification needed after release", seen_row, 1'b0);
        play(4000);
        check_out("R8 requalified after release", 3, 2);
        silence(1200);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule